// File: doc/BRIEF.md
# Interrupt Level Acceptance Controller

This block decides whether a CPU core takes an interrupt. It keeps a global enable flag and a 2-bit current-level field. It also holds a 2-bit priority level for each of twelve peripheral request lines. Every cycle it compares the pending requests with the current level. A request is eligible only when the enable flag is set and the request's programmed level is numerically below the current level. Level 0 is the most urgent, and level 3 means "never interrupt".

When a request is taken, the block pulses an accept strobe with the 4-bit source index. At the same edge it loads the current level with the winner's level. From then on, only strictly more urgent requests can nest on top of it. The core issues set-enable and clear-enable commands. On return it hands back a saved enable bit and level, and the block restores both. Per-source levels are programmed through a small write port of 8-bit registers.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the enable flag is 0, the current level is 3, accept is 0, and every source level is 3. With only set-enable issued after reset, no request is ever accepted.
- R2: While the enable flag is 0, no request is accepted.
- R3: A request is eligible only if its level is strictly less than the current level. A source programmed to 3 is never accepted.
- R4: Among eligible requests, the lowest level value wins. Ties go to the lowest source index.
- R5: Accept rises in the cycle after the edge that sees an eligible request, and lasts one cycle. In that cycle acceptIdx gives the winner, and curLevel already holds the winner's level.
- R6: setEn writes the enable flag to 1 and clrEn writes it to 0, both effective at the next edge. When both are high, clear wins.
- R7: retiValid loads the enable flag from retiEn and the current level from retiLevel. In that cycle it suppresses acceptance and overrides setEn and clrEn.
- R8: Writing with cfgWe and cfgAddr = r (r = 0..2) sets sources 4r..4r+3. Source 4r sits in bits 1:0, 4r+1 in bits 3:2, 4r+2 in bits 5:4 and 4r+3 in bits 7:6. A write to address 3 changes nothing.
- R9: Requests are level-sensitive. A request withdrawn before it is eligible is not remembered.
- R10: If clrEn arrives in the same cycle as an eligible request, that request is still accepted and the enable flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 12 | Level-sensitive request lines, bit i is source i |
| setEn | input | 1 | Set-enable command |
| clrEn | input | 1 | Clear-enable command |
| retiValid | input | 1 | Return strobe: restore saved status |
| retiEn | input | 1 | Saved enable bit |
| retiLevel | input | 2 | Saved current level |
| cfgWe | input | 1 | Level register write enable |
| cfgAddr | input | 2 | Level register address |
| cfgWdata | input | 8 | Four packed 2-bit source levels |
| accept | output | 1 | One-cycle acceptance strobe |
| acceptIdx | output | 4 | Index of the accepted source |
| intEnable | output | 1 | Current enable flag |
| curLevel | output | 2 | Current interrupt level |

## Verification
Three pairs of functions can fall on the same clock edge: a return strobe and an eligible request, set-enable and clear-enable together, and clear-enable and an acceptance. The bench provokes each pair by driving both inputs in the same cycle. For the return case, the bench expects no accept pulse and the saved level and enable to be loaded. When set and clear collide, the flag must end at 0. For clear-enable with an acceptance, the accept pulse must still appear with the correct index and level while the flag drops to 0.

// File: rtl/irqlvl_pkg.sv
package irqlvl_pkg;
  // Strobes from control to datapath, one per state update
  typedef struct packed {
    logic ldReti;  // restore level and enable from saved status
    logic ldWin;   // capture winner index and load its level
    logic enSet;   // write enable flag to 1
    logic enClr;   // write enable flag to 0
  } lvlStrobe_t;
endpackage

// File: rtl/irqlvl_datapath.sv
module irqlvl_datapath
  import irqlvl_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int LVL_W   = 2,
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 2,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [REG_W-1:0]   cfgWdata,
  input  logic               retiEn,
  input  logic [LVL_W-1:0]   retiLevel,
  input  lvlStrobe_t         strobe,
  output logic               winValid,
  output logic               intEnable,
  output logic [LVL_W-1:0]   curLevel,
  output logic [IDX_W-1:0]   acceptIdx
);
  localparam int FIELDS = REG_W / LVL_W;

  logic [NUM_SRC-1:0][LVL_W-1:0] srcLvl;
  logic [NUM_SRC-1:0]            eligible;
  logic                          enQ;
  logic [LVL_W-1:0]              curQ;
  logic [IDX_W-1:0]              idxQ;
  logic [LVL_W-1:0]              bestLvl;
  logic [IDX_W-1:0]              bestIdx;
  logic                          found;

  // Per-source level registers and eligibility compare
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int REG_SEL = s / FIELDS;
    localparam int FLD_LSB = (s % FIELDS) * LVL_W;
    logic [LVL_W-1:0] lvlQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        lvlQ <= '1;
      else if (cfgWe && cfgAddr == ADDR_W'(REG_SEL))
        lvlQ <= cfgWdata[FLD_LSB +: LVL_W];
    end
    assign srcLvl[s]   = lvlQ;
    assign eligible[s] = irqReq[s] && (lvlQ < curQ);
  end

  // Lowest level wins; scanning downward with <= keeps the lowest index on ties
  always_comb begin
    bestLvl = '1;
    bestIdx = '0;
    found   = 1'b0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (eligible[s] && srcLvl[s] <= bestLvl) begin
        bestLvl = srcLvl[s];
        bestIdx = IDX_W'(s);
        found   = 1'b1;
      end
    end
  end

  assign winValid = found && enQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      curQ <= '1;
      idxQ <= '0;
    end else begin
      if (strobe.ldReti)     curQ <= retiLevel;
      else if (strobe.ldWin) curQ <= bestLvl;

      if (strobe.ldWin) idxQ <= bestIdx;

      if (strobe.ldReti)     enQ <= retiEn;
      else if (strobe.enClr) enQ <= 1'b0;
      else if (strobe.enSet) enQ <= 1'b1;
    end
  end

  assign intEnable = enQ;
  assign curLevel  = curQ;
  assign acceptIdx = idxQ;
endmodule

// File: rtl/irqlvl_control.sv
module irqlvl_control
  import irqlvl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       retiValid,
  input  logic       setEn,
  input  logic       clrEn,
  input  logic       winValid,
  output lvlStrobe_t strobe,
  output logic       accept
);
  logic acceptQ;

  // Return has top priority; clear beats set
  always_comb begin
    strobe.ldReti = retiValid;
    strobe.ldWin  = winValid && !retiValid;
    strobe.enClr  = clrEn && !retiValid;
    strobe.enSet  = setEn && !clrEn && !retiValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) acceptQ <= 1'b0;
    else       acceptQ <= strobe.ldWin;
  end

  assign accept = acceptQ;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irqlvl_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int LVL_W   = 2,
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 2,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               setEn,
  input  logic               clrEn,
  input  logic               retiValid,
  input  logic               retiEn,
  input  logic [LVL_W-1:0]   retiLevel,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [REG_W-1:0]   cfgWdata,
  output logic               accept,
  output logic [IDX_W-1:0]   acceptIdx,
  output logic               intEnable,
  output logic [LVL_W-1:0]   curLevel
);
  lvlStrobe_t strobe;
  logic       winValid;

  irqlvl_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .retiValid (retiValid),
    .setEn     (setEn),
    .clrEn     (clrEn),
    .winValid  (winValid),
    .strobe    (strobe),
    .accept    (accept)
  );

  irqlvl_datapath #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W),
    .REG_W   (REG_W),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqReq    (irqReq),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .retiEn    (retiEn),
    .retiLevel (retiLevel),
    .strobe    (strobe),
    .winValid  (winValid),
    .intEnable (intEnable),
    .curLevel  (curLevel),
    .acceptIdx (acceptIdx)
  );
endmodule

// File: rtl/irqlvl_chk.sv
module irqlvl_chk #(
  parameter int NUM_SRC = 12,
  parameter int LVL_W   = 2,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic             clk,
  input logic             rstN,
  input logic             setEn,
  input logic             clrEn,
  input logic             retiValid,
  input logic             retiEn,
  input logic [LVL_W-1:0] retiLevel,
  input logic             accept,
  input logic [IDX_W-1:0] acceptIdx,
  input logic             intEnable,
  input logic [LVL_W-1:0] curLevel
);
  // R2
  accept_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> $past(intEnable));

  // R3
  accept_lowers_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (curLevel < $past(curLevel)));

  // R5
  accept_index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (acceptIdx < IDX_W'(NUM_SRC)));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && !retiValid) |=> !intEnable);

  // R6
  set_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setEn && !clrEn && !retiValid) |=> intEnable);

  // R7
  reti_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    retiValid |=> (!accept && curLevel == $past(retiLevel) && intEnable == $past(retiEn)));
endmodule

bind irq_level_ctrl irqlvl_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] irqReq = '0;
  logic        setEn = 1'b0;
  logic        clrEn = 1'b0;
  logic        retiValid = 1'b0;
  logic        retiEn = 1'b0;
  logic [1:0]  retiLevel = '0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [7:0]  cfgWdata = '0;
  logic        accept;
  logic [3:0]  acceptIdx;
  logic        intEnable;
  logic [1:0]  curLevel;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_level_ctrl uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .setEn(setEn), .clrEn(clrEn),
    .retiValid(retiValid), .retiEn(retiEn), .retiLevel(retiLevel),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .accept(accept), .acceptIdx(acceptIdx), .intEnable(intEnable), .curLevel(curLevel)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [7:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic doReti(input logic [1:0] lvl, input logic en);
    retiValid = 1'b1; retiLevel = lvl; retiEn = en;
    step();
    retiValid = 1'b0;
  endtask

  task automatic pulseSet();
    setEn = 1'b1; step(); setEn = 1'b0;
  endtask

  task automatic pulseClr();
    clrEn = 1'b1; step(); clrEn = 1'b0;
  endtask

  task automatic expectTake(input string tag, input int idx, input int lvl);
    step();
    chk({tag, " accept"}, int'(accept), 1);
    chk({tag, " index"}, int'(acceptIdx), idx);
    chk({tag, " level"}, int'(curLevel), lvl);
  endtask

  task automatic testReset();
    chk("R1 accept at reset", int'(accept), 0);
    chk("R1 enable at reset", int'(intEnable), 0);
    chk("R1 level at reset", int'(curLevel), 3);
  endtask

  task automatic testDefaultLevels();
    pulseSet();
    chk("R6 set-enable", int'(intEnable), 1);
    irqReq = 12'hFFF;
    step(); chk("R1 default level 3 blocks", int'(accept), 0);
    step(); chk("R1 default level 3 blocks again", int'(accept), 0);
    irqReq = '0;
  endtask

  task automatic testConfig();
    // src0=2 src1=1 src2=0 src3=3 ; src4..7=1 ; src8=0 src9=0 src10=2 src11=3
    cfgWrite(2'd0, 8'hC6);
    cfgWrite(2'd1, 8'h55);
    cfgWrite(2'd2, 8'hE0);
    cfgWrite(2'd3, 8'h00);
    irqReq = 12'h008;
    step(); chk("R8 address 3 ignored, source 3 still level 3", int'(accept), 0);
    irqReq = 12'h010;
    expectTake("R8 source 4 field of register 1", 4, 1);
    irqReq = '0;
    doReti(2'd3, 1'b1);
  endtask

  task automatic testPriority();
    irqReq = 12'h013;
    expectTake("R4 lowest level wins", 1, 1);
    irqReq = '0; doReti(2'd3, 1'b1);
    irqReq = 12'h300;
    expectTake("R4 tie to lowest index", 8, 0);
    irqReq = '0; doReti(2'd3, 1'b1);
    irqReq = 12'h104;
    expectTake("R4 tie across registers", 2, 0);
    irqReq = '0; doReti(2'd3, 1'b1);
  endtask

  task automatic testStrict();
    doReti(2'd1, 1'b1);
    irqReq = 12'h002;
    step(); chk("R3 equal level not taken", int'(accept), 0);
    irqReq = 12'h006;
    expectTake("R3 lower level nests", 2, 0);
    irqReq = '0; doReti(2'd3, 1'b1);
  endtask

  task automatic testPulse();
    irqReq = 12'h001;
    expectTake("R5 accept pulse", 0, 2);
    step();
    chk("R5 pulse ends while request held", int'(accept), 0);
    chk("R5 level holds", int'(curLevel), 2);
    irqReq = '0; doReti(2'd3, 1'b1);
  endtask

  task automatic testDisable();
    pulseClr();
    chk("R6 clear-enable", int'(intEnable), 0);
    irqReq = 12'h004;
    step(); chk("R2 disabled blocks", int'(accept), 0);
    step(); chk("R2 disabled blocks again", int'(accept), 0);
    irqReq = '0;
  endtask

  task automatic testSetClr();
    setEn = 1'b1; clrEn = 1'b1;
    step();
    setEn = 1'b0; clrEn = 1'b0;
    chk("R6 clear beats set", int'(intEnable), 0);
    pulseSet();
    chk("R6 set after collision", int'(intEnable), 1);
  endtask

  task automatic testLevelSense();
    pulseClr();
    irqReq = 12'h004;
    step();
    irqReq = '0;
    pulseSet();
    chk("R9 withdrawn request not latched", int'(accept), 0);
    step();
    chk("R9 withdrawn request not latched later", int'(accept), 0);
  endtask

  task automatic testRetiCollide();
    irqReq = 12'h004;
    retiValid = 1'b1; retiLevel = 2'd0; retiEn = 1'b1;
    step();
    retiValid = 1'b0;
    chk("R7 return suppresses accept", int'(accept), 0);
    chk("R7 return loads level", int'(curLevel), 0);
    chk("R7 return loads enable", int'(intEnable), 1);
    irqReq = '0;
    retiValid = 1'b1; retiLevel = 2'd3; retiEn = 1'b0; setEn = 1'b1;
    step();
    retiValid = 1'b0; setEn = 1'b0;
    chk("R7 return overrides set-enable", int'(intEnable), 0);
    chk("R7 return restores level 3", int'(curLevel), 3);
  endtask

  task automatic testClrCollide();
    pulseSet();
    irqReq = 12'h004; clrEn = 1'b1;
    step();
    clrEn = 1'b0; irqReq = '0;
    chk("R10 accept survives clear", int'(accept), 1);
    chk("R10 index", int'(acceptIdx), 2);
    chk("R10 level", int'(curLevel), 0);
    chk("R10 enable cleared", int'(intEnable), 0);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    testReset();
    testDefaultLevels();
    testConfig();
    testPriority();
    testStrict();
    testPulse();
    testDisable();
    testSetClr();
    testLevelSense();
    testRetiCollide();
    testClrCollide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule